// File: doc/BRIEF.md
# SMBus Block Data Buffer

This block stores the bytes of one SMBus block transfer in a 32-entry array and offers two ways into it. The host reaches every entry through a single byte-wide register. A hidden host index picks the entry. Each read or write of that register moves the index on by one. A read of the host control register sends the index back to entry 0. This lets software set the index to a known place before it fills or drains the array.

The second way in belongs to the SMBus engine. It has its own index, which a start strobe clears at the beginning of every block transaction. During an SMBus read the engine fills the array from entry 0 upward. During an SMBus write it drains the array from entry 0 upward. One byte strobe moves the engine index by one entry.

The array contents are not initialised by reset. Both indices reset to 0.

Top module: `smb_blkbuf`

## Requirements
- R1: A host read at offset 7h (the data port) returns, in the same cycle, the byte stored at the host index. The host index then advances by one.
- R2: A host write at offset 7h stores `hst_wdata` at the host index. The host index then advances by one.
- R3: A host read at offset 2h (the control register) sets the host index to 0. A host write at offset 2h leaves the host index unchanged.
- R4: The host index steps from 31 back to 0, so a 33rd consecutive write lands on entry 0 again.
- R5: A host access at any offset other than 7h leaves the array unchanged. So does a host access at 2h. An access at any offset other than 2h and 7h also leaves the host index unchanged. `hst_rdata` is 00h in every cycle that is not a data port read.
- R6: `eng_start` sets the engine index to 0. When `eng_start` and `eng_byte` are high in the same cycle, the byte strobe is ignored: nothing is stored and the index ends at 0.
- R7: `eng_rdata` always shows the byte at the engine index. `eng_byte` advances the engine index by one, with a wrap from 31 to 0. When `eng_fill` is 1, `eng_byte` also stores `eng_wdata` at the engine index first. When `eng_fill` is 0, nothing is stored.
- R8: If the engine stores a byte in the same cycle as a host data port write, the host byte is discarded. The host index still advances.
- R9: After reset both indices are 0, and `hst_rdata` is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hst_addr | input | 4 | Host register offset |
| hst_rd | input | 1 | Host read strobe |
| hst_wr | input | 1 | Host write strobe |
| hst_wdata | input | 8 | Host write byte |
| hst_rdata | output | 8 | Host read byte (data port only, else 00h) |
| eng_start | input | 1 | Engine transaction start, clears engine index |
| eng_byte | input | 1 | Engine byte strobe |
| eng_fill | input | 1 | 1: engine stores bytes, 0: engine only reads |
| eng_wdata | input | 8 | Byte from the engine |
| eng_rdata | output | 8 | Byte at the engine index |

## Verification
The hardest case to reach from the ports is the two sides touching the array in the same cycle. In that case the host index and the engine index point at different entries, and a host write is either dropped or a start strobe masks a byte strobe. Host index wrap is also hard to reach. The random stimulus drives host and engine operations independently every cycle, so collisions and start/byte overlaps arise often. A bench model of the array and of both indices predicts every read byte. Directed sequences cover a 33-write wrap, a control write that must not clear the index, and a start strobe coinciding with a byte strobe.

// File: rtl/smb_blkbuf_pkg.sv
package smb_blkbuf_pkg;
    localparam int unsigned DEPTH  = 32;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned ADDR_W = 4;
    localparam int unsigned IDX_W  = $clog2(DEPTH);

    localparam logic [ADDR_W-1:0] DATA_OFS = 4'h7;
    localparam logic [ADDR_W-1:0] CTRL_OFS = 4'h2;

    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [DATA_W-1:0] byte_t;

    typedef enum logic [1:0] {
        HOP_NONE,
        HOP_DATA_RD,
        HOP_DATA_WR,
        HOP_CTRL_RD
    } hop_e;

    typedef struct packed {
        logic  en;
        idx_t  idx;
        byte_t data;
    } wr_req_t;

    function automatic idx_t idx_next(idx_t cur);
        if (cur == idx_t'(DEPTH - 1))
            return '0;
        return cur + 1'b1;
    endfunction
endpackage

// File: rtl/smb_hst_port.sv
module smb_hst_port
    import smb_blkbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  byte_t             wdata,
    output hop_e              hop,
    output idx_t              idx,
    output wr_req_t           wreq
);
    idx_t idx_q;

    always_comb begin
        hop = HOP_NONE;
        if (addr == DATA_OFS) begin
            if (rd)
                hop = HOP_DATA_RD;
            else if (wr)
                hop = HOP_DATA_WR;
        end else if (addr == CTRL_OFS && rd) begin
            hop = HOP_CTRL_RD;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            idx_q <= '0;
        else begin
            case (hop)
                HOP_CTRL_RD: idx_q <= '0;
                HOP_DATA_RD,
                HOP_DATA_WR: idx_q <= idx_next(idx_q);
                default:     idx_q <= idx_q;
            endcase
        end
    end

    assign idx       = idx_q;
    assign wreq.en   = (hop == HOP_DATA_WR);
    assign wreq.idx  = idx_q;
    assign wreq.data = wdata;
endmodule

// File: rtl/smb_eng_port.sv
module smb_eng_port
    import smb_blkbuf_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  logic    byte_stb,
    input  logic    fill,
    input  byte_t   wdata,
    output idx_t    idx,
    output wr_req_t wreq
);
    idx_t idx_q;
    logic step;

    assign step = byte_stb && !start;

    always_ff @(posedge clk) begin
        if (rst || start)
            idx_q <= '0;
        else if (step)
            idx_q <= idx_next(idx_q);
    end

    assign idx       = idx_q;
    assign wreq.en   = step && fill;
    assign wreq.idx  = idx_q;
    assign wreq.data = wdata;
endmodule

// File: rtl/smb_blk_store.sv
module smb_blk_store
    import smb_blkbuf_pkg::*;
(
    input  logic    clk,
    input  wr_req_t hst_req,
    input  wr_req_t eng_req,
    input  idx_t    hst_idx,
    input  idx_t    eng_idx,
    output byte_t   hst_byte,
    output byte_t   eng_byte
);
    byte_t mem [DEPTH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (eng_req.en && eng_req.idx == idx_t'(i))
                mem[i] <= eng_req.data;
            else if (hst_req.en && !eng_req.en && hst_req.idx == idx_t'(i))
                mem[i] <= hst_req.data;
        end
    end

    assign hst_byte = mem[hst_idx];
    assign eng_byte = mem[eng_idx];
endmodule

// File: rtl/smb_blkbuf.sv
module smb_blkbuf
    import smb_blkbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] hst_addr,
    input  logic              hst_rd,
    input  logic              hst_wr,
    input  logic [DATA_W-1:0] hst_wdata,
    output logic [DATA_W-1:0] hst_rdata,
    input  logic              eng_start,
    input  logic              eng_byte,
    input  logic              eng_fill,
    input  logic [DATA_W-1:0] eng_wdata,
    output logic [DATA_W-1:0] eng_rdata
);
    hop_e    hop;
    idx_t    hst_idx;
    idx_t    eng_idx;
    wr_req_t hst_req;
    wr_req_t eng_req;
    byte_t   hst_byte;

    smb_hst_port u_hst (
        .clk   (clk),
        .rst   (rst),
        .addr  (hst_addr),
        .rd    (hst_rd),
        .wr    (hst_wr),
        .wdata (hst_wdata),
        .hop   (hop),
        .idx   (hst_idx),
        .wreq  (hst_req)
    );

    smb_eng_port u_eng (
        .clk      (clk),
        .rst      (rst),
        .start    (eng_start),
        .byte_stb (eng_byte),
        .fill     (eng_fill),
        .wdata    (eng_wdata),
        .idx      (eng_idx),
        .wreq     (eng_req)
    );

    smb_blk_store u_store (
        .clk      (clk),
        .hst_req  (hst_req),
        .eng_req  (eng_req),
        .hst_idx  (hst_idx),
        .eng_idx  (eng_idx),
        .hst_byte (hst_byte),
        .eng_byte (eng_rdata)
    );

    assign hst_rdata = (hop == HOP_DATA_RD) ? hst_byte : '0;
endmodule

// File: rtl/smb_blkbuf_chk.sv
module smb_blkbuf_chk
    import smb_blkbuf_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] hst_addr,
    input logic              hst_rd,
    input logic              hst_wr,
    input logic [DATA_W-1:0] hst_rdata,
    input logic              eng_start,
    input logic              eng_byte,
    input idx_t              hst_idx,
    input idx_t              eng_idx
);
    logic data_acc;
    logic ctrl_rd;
    assign data_acc = (hst_addr == DATA_OFS) && (hst_rd || hst_wr);
    assign ctrl_rd  = (hst_addr == CTRL_OFS) && hst_rd;

    // R3
    ctrl_rd_clears_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_rd |=> hst_idx == '0);

    // R1
    data_acc_steps_chk: assert property (@(posedge clk) disable iff (rst)
        data_acc |=> hst_idx == idx_next($past(hst_idx)));

    // R5
    other_acc_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (!data_acc && !ctrl_rd) |=> $stable(hst_idx));

    // R5
    rdata_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !(hst_rd && hst_addr == DATA_OFS) |-> hst_rdata == '0);

    // R6
    eng_start_clears_chk: assert property (@(posedge clk) disable iff (rst)
        eng_start |=> eng_idx == '0);

    // R7
    eng_byte_steps_chk: assert property (@(posedge clk) disable iff (rst)
        (eng_byte && !eng_start) |=> eng_idx == idx_next($past(eng_idx)));

    // R7
    eng_idle_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (!eng_byte && !eng_start) |=> $stable(eng_idx));

    // R9
    reset_idx_zero_chk: assert property (@(posedge clk)
        rst |=> (hst_idx == '0 && eng_idx == '0));
endmodule

bind smb_blkbuf smb_blkbuf_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .hst_addr  (hst_addr),
    .hst_rd    (hst_rd),
    .hst_wr    (hst_wr),
    .hst_rdata (hst_rdata),
    .eng_start (eng_start),
    .eng_byte  (eng_byte),
    .hst_idx   (hst_idx),
    .eng_idx   (eng_idx)
);

// File: tb/smb_blkbuf_tb.sv
module smb_blkbuf_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] hst_addr;
    logic       hst_rd, hst_wr;
    logic [7:0] hst_wdata, hst_rdata;
    logic       eng_start, eng_byte, eng_fill;
    logic [7:0] eng_wdata, eng_rdata;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] m_mem [32];
    logic [4:0] m_hidx;
    logic [4:0] m_eidx;

    localparam logic [3:0] A_DATA = 4'h7;
    localparam logic [3:0] A_CTRL = 4'h2;

    always #4 clk = ~clk;

    smb_blkbuf u_dut (
        .clk(clk), .rst(rst),
        .hst_addr(hst_addr), .hst_rd(hst_rd), .hst_wr(hst_wr),
        .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
        .eng_start(eng_start), .eng_byte(eng_byte), .eng_fill(eng_fill),
        .eng_wdata(eng_wdata), .eng_rdata(eng_rdata)
    );

    function automatic logic [7:0] exp_hst(logic [3:0] a, logic rd, logic [4:0] hi);
        if (rd && a == A_DATA)
            return m_mem[hi];
        return 8'h00;
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic step(logic [3:0] a, logic rd, logic wr, logic [7:0] hw,
                        logic es, logic eb, logic ef, logic [7:0] ew, string req);
        logic ewr;
        @(negedge clk);
        hst_addr = a; hst_rd = rd; hst_wr = wr; hst_wdata = hw;
        eng_start = es; eng_byte = eb; eng_fill = ef; eng_wdata = ew;
        #1;
        check(req, hst_rdata, exp_hst(a, rd, m_hidx));
        check(req, eng_rdata, m_mem[m_eidx]);
        @(posedge clk);
        ewr = eb && !es && ef;
        if (ewr) m_mem[m_eidx] = ew;
        if (wr && !rd && a == A_DATA && !ewr) m_mem[m_hidx] = hw;
        if (rd && a == A_CTRL) m_hidx = 5'd0;
        else if ((rd || wr) && a == A_DATA) m_hidx = m_hidx + 5'd1;
        if (es) m_eidx = 5'd0;
        else if (eb) m_eidx = m_eidx + 5'd1;
    endtask

    task automatic idle();
        step(4'h0, 0, 0, 8'h00, 0, 0, 0, 8'h00, "R5");
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = 32'd7321;
        void'($urandom(seed));
        rst = 1'b1;
        hst_addr = '0; hst_rd = 0; hst_wr = 0; hst_wdata = '0;
        eng_start = 0; eng_byte = 0; eng_fill = 0; eng_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_hidx = '0; m_eidx = '0;
        for (int i = 0; i < 32; i++) m_mem[i] = 8'hxx;
        #1;
        check("R9", hst_rdata, 8'h00);

        // R9: both indices at 0 -> host write at entry 0 seen by engine
        @(posedge clk);
        step(A_DATA, 0, 1, 8'hA5, 0, 0, 0, 8'h00, "R9");
        #1;
        check("R9", eng_rdata, 8'hA5);

        // R2 / R4: fill all entries, then a 33rd write wraps to entry 0
        for (int i = 1; i < 32; i++)
            step(A_DATA, 0, 1, 8'(i * 7 + 3), 0, 0, 0, 8'h00, "R2");
        step(A_DATA, 0, 1, 8'h5C, 0, 0, 0, 8'h00, "R4");
        step(A_CTRL, 1, 0, 8'h00, 0, 0, 0, 8'h00, "R3");
        step(A_DATA, 1, 0, 8'h00, 0, 0, 0, 8'h00, "R4");
        step(A_DATA, 1, 0, 8'h00, 0, 0, 0, 8'h00, "R1");

        // R3: control write must not clear the index
        step(A_CTRL, 0, 1, 8'hFF, 0, 0, 0, 8'h00, "R3");
        step(A_DATA, 1, 0, 8'h00, 0, 0, 0, 8'h00, "R3");
        // R5: other offset write has no effect
        step(4'h5, 0, 1, 8'h33, 0, 0, 0, 8'h00, "R5");
        step(4'h5, 1, 0, 8'h00, 0, 0, 0, 8'h00, "R5");
        step(A_DATA, 1, 0, 8'h00, 0, 0, 0, 8'h00, "R5");

        // R6: start with byte strobe -> no store, index 0
        step(A_DATA, 0, 0, 8'h00, 0, 1, 0, 8'h00, "R7");
        step(A_DATA, 0, 0, 8'h00, 1, 1, 1, 8'hEE, "R6");
        idle();
        // R7: engine fill then drain
        step(4'h0, 0, 0, 8'h00, 0, 1, 1, 8'h11, "R7");
        step(4'h0, 0, 0, 8'h00, 0, 1, 1, 8'h22, "R7");
        step(4'h0, 0, 0, 8'h00, 1, 0, 0, 8'h00, "R6");
        step(4'h0, 0, 0, 8'h00, 0, 1, 0, 8'h00, "R7");
        step(4'h0, 0, 0, 8'h00, 0, 1, 0, 8'h00, "R7");

        // R8: collision, host write dropped but host index advances
        step(A_CTRL, 1, 0, 8'h00, 1, 0, 0, 8'h00, "R3");
        step(A_DATA, 0, 1, 8'h99, 0, 1, 1, 8'h44, "R8");
        step(A_DATA, 0, 1, 8'h77, 0, 0, 0, 8'h00, "R8");
        step(A_CTRL, 1, 0, 8'h00, 0, 0, 0, 8'h00, "R8");
        step(A_DATA, 1, 0, 8'h00, 0, 0, 0, 8'h00, "R8");
        step(A_DATA, 1, 0, 8'h00, 0, 0, 0, 8'h00, "R8");

        // random mix
        for (int n = 0; n < 3000; n++) begin
            int unsigned hs, es;
            logic [3:0] a;
            logic rd, wr, st, eb;
            hs = $urandom % 8;
            es = $urandom % 6;
            rd = 0; wr = 0; a = 4'($urandom % 16);
            case (hs)
                0, 1: begin a = A_DATA; rd = 1; end
                2, 3: begin a = A_DATA; wr = 1; end
                4:    begin a = A_CTRL; rd = 1; end
                5:    begin wr = 1; end
                6:    begin rd = (a != A_DATA); end
                default: ;
            endcase
            st = (es == 0);
            eb = (es >= 2) || ($urandom % 4 == 0);
            step(a, rd, wr, 8'($urandom), st, eb, 1'($urandom),
                 8'($urandom), (hs < 2) ? "R1" : (wr && a == A_DATA) ? "R8" : "R7");
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule